// File: doc/BRIEF.md
# Programmable Watchdog Reset Timer

This block supervises a processor by watching for regular activity on a strobe input. A two-bit delay code in a byte-wide control register picks one of three timeout periods or turns the timer off. Each high-to-low transition on the strobe restarts the timeout from its full length. If the strobe stays quiet for the whole period, the block drives an active-low reset output for a fixed pulse length. It then releases the reset and starts timing again.

The time base is a millisecond tick made by dividing the clock by a parameter derived from the clock frequency. The period lengths and the pulse length are parameters counted in ticks. This keeps the block usable in short simulations. Software reaches the control register through a plain write strobe with an 8-bit data bus and an 8-bit read bus that always shows the register.

Top module: `wdt_supervisor`

## Requirements
- R1: The delay code in register bits [1:0] selects the timeout, counted in millisecond ticks of CLK_HZ/1000 cycles. Code 2'b01 selects SHORT_MS, 2'b10 selects MID_MS and 2'b11 selects LONG_MS. After a restart taken at clock edge E, the reset output goes low right after edge E + period_ms × CLK_HZ/1000.
- R2: A synchronous power-on reset (rst_n low) sets the delay code to 2'b11 and drives wd_rst_n high. Timing starts from the last edge at which rst_n is sampled low.
- R3: The strobe passes through two synchronizing flip-flops. A high-to-low transition restarts the count at the third clock edge after the strobe changes. A low-to-high transition has no effect on the timing.
- R4: While wd_rst_n is low, strobe edges are ignored. The timeout count begins again, from zero, at the edge where wd_rst_n returns high.
- R5: On expiry, wd_rst_n is held low for exactly PULSE_MS × CLK_HZ/1000 clock cycles.
- R6: reg_rd_data always returns {6'b0, code}. A write stores reg_wr_data[1:0] and discards bits [7:2].
- R7: Writing code 2'b00 clears the count and suppresses any pending timeout. No reset pulse is produced while the code stays 2'b00.
- R8: Writing a nonzero code while counting restarts the count from zero at the write edge, using the period of the new code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| reg_wr_en | input | 1 | Write strobe for the control register |
| reg_wr_data | input | 8 | Write data; bits [1:0] form the delay code |
| reg_rd_data | output | 8 | Register read value, upper six bits zero |
| strobe_in | input | 1 | Asynchronous activity strobe; falling edge restarts timing |
| wd_rst_n | output | 1 | Active-low reset output |

## Verification
The bench measures the exact cycle of every reset-output transition. A miscounted prescaler or an off-by-one expiry compare therefore shows up as a wrong cycle count rather than passing loosely. It raises the strobe alone to catch a design that restarts on either edge: such a design would expire three cycles late. It toggles the strobe during a reset pulse to catch a design that lets the strobe stretch the pulse or restart the count early. It also writes code 00 just before expiry to catch a design that leaves a stale count armed, and rewrites the code mid-count to catch one that keeps the old period or the old count.

// File: rtl/wdt_pkg.sv
// Shared types for the watchdog supervisor.
// Assumes: delay code is two bits; 2'b00 means disabled.
package wdt_pkg;
    typedef logic [1:0] delay_code_t;

    localparam delay_code_t CODE_OFF   = 2'b00;
    localparam delay_code_t CODE_SHORT = 2'b01;
    localparam delay_code_t CODE_MID   = 2'b10;
    localparam delay_code_t CODE_LONG  = 2'b11;

    typedef enum logic {
        ST_COUNT = 1'b0,
        ST_PULSE = 1'b1
    } wdt_state_e;
endpackage

// File: rtl/wdt_tick_gen.sv
// Millisecond tick prescaler.
// Produces a one-cycle tick every CYCLES_PER_MS clocks. tick_clr zeroes
// the phase so that the first tick arrives CYCLES_PER_MS cycles later.
// Assumes CYCLES_PER_MS >= 1.
module wdt_tick_gen #(
    parameter int CYCLES_PER_MS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_clr,
    output logic ms_tick
);
    localparam int PW = (CYCLES_PER_MS > 1) ? $clog2(CYCLES_PER_MS) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(CYCLES_PER_MS - 1);

    logic [PW-1:0] pre_cnt;

    assign ms_tick = (pre_cnt == PRE_LAST);

    // Advance the prescaler, wrapping on each tick or clearing on request.
    always_ff @(posedge clk) begin
        if (!rst_n || tick_clr || ms_tick) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    generate
        if (CYCLES_PER_MS > 1) begin : g_spacing
            // R1
            tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ms_tick |=> !ms_tick);
        end
    endgenerate
endmodule

// File: rtl/wdt_strobe_sync.sv
// Strobe synchronizer and falling-edge detector.
// Two flops bring the asynchronous strobe into the clock domain; a third
// holds the previous synchronized level. fall_pulse is one cycle wide.
// Assumes the strobe stays stable for at least two clock cycles.
module wdt_strobe_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_in,
    output logic fall_pulse
);
    logic meta_q, sync_q, prev_q;

    // Shift the strobe through the synchronizer and the history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= strobe_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign fall_pulse = prev_q & ~sync_q;

    // R3
    fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_pulse |=> !fall_pulse);
endmodule

// File: rtl/wdt_ctrl_reg.sv
// Byte-wide watchdog control register.
// Holds the two-bit delay code; upper bits read back as zero.
// Resets to the longest period with the timer enabled.
module wdt_ctrl_reg
    import wdt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    output logic [7:0]  rd_data,
    output delay_code_t code
);
    logic unused_hi_bits;
    assign unused_hi_bits = ^wr_data[7:2];

    // Capture the delay code on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code <= CODE_LONG;
        end else if (wr_en) begin
            code <= wr_data[1:0];
        end
    end

    assign rd_data = {6'b0, code};

    // R6
    wr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data == {6'b0, $past(wr_data[1:0])});
endmodule

// File: rtl/wdt_timer_core.sv
// Timeout counter and reset-pulse sequencer.
// In ST_COUNT it counts ticks toward the selected period. A restart
// (strobe fall or register write) zeroes the count, and code 00 holds it
// at zero. On expiry it enters ST_PULSE and drives rst_out_n low for
// PULSE_MS ticks, ignoring restarts. It then returns to ST_COUNT from zero.
// Assumes ms_tick phase is cleared whenever tick_clr is raised.
module wdt_timer_core
    import wdt_pkg::*;
#(
    parameter int SHORT_MS = 250,
    parameter int MID_MS   = 500,
    parameter int LONG_MS  = 1000,
    parameter int PULSE_MS = 250
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ms_tick,
    input  logic        strobe_fall,
    input  logic        cfg_write,
    input  delay_code_t code,
    output logic        tick_clr,
    output logic        rst_out_n
);
    localparam int MAX_MS = (LONG_MS > PULSE_MS) ? LONG_MS : PULSE_MS;
    localparam int CW     = $clog2(MAX_MS + 1);
    localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_MS - 1);
    localparam logic [CW-1:0] MID_LAST   = CW'(MID_MS - 1);
    localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_MS - 1);
    localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_MS - 1);

    wdt_state_e    state;
    logic [CW-1:0] cnt;
    logic [CW-1:0] period_last;
    logic          enabled;
    logic          restart;

    // Map the delay code to the last tick index of its period.
    always_comb begin
        unique case (code)
            CODE_SHORT: period_last = SHORT_LAST;
            CODE_MID:   period_last = MID_LAST;
            default:    period_last = LONG_LAST;
        endcase
    end

    assign enabled  = (code != CODE_OFF);
    assign restart  = strobe_fall | cfg_write;
    assign tick_clr = (state == ST_COUNT) && (restart || !enabled);

    // Sequence counting, expiry and the reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_COUNT;
            cnt       <= '0;
            rst_out_n <= 1'b1;
        end else begin
            unique case (state)
                ST_COUNT: begin
                    if (!enabled || restart) begin
                        cnt <= '0;
                    end else if (ms_tick) begin
                        if (cnt == period_last) begin
                            state     <= ST_PULSE;
                            cnt       <= '0;
                            rst_out_n <= 1'b0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_PULSE: begin
                    if (ms_tick) begin
                        if (cnt == PULSE_LAST) begin
                            state     <= ST_COUNT;
                            cnt       <= '0;
                            rst_out_n <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: state <= ST_COUNT;
            endcase
        end
    end

    // R5
    pulse_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PULSE) |-> (cnt <= PULSE_LAST));

    // R1
    period_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && enabled) |-> (cnt <= period_last));

    // R1
    expiry_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_out_n) |-> $past(ms_tick));

    // R7
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && !enabled) |=> (rst_out_n && cnt == '0));

    // R4
    pulse_ignores_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PULSE && strobe_fall && !ms_tick) |=> (state == ST_PULSE));
endmodule

// File: rtl/wdt_supervisor.sv
// Watchdog supervisor top level.
// Joins the control register, strobe synchronizer, millisecond prescaler
// and timeout core. wd_rst_n is the active-low reset output.
// Assumes CLK_HZ is a multiple of 1000.
module wdt_supervisor #(
    parameter int CLK_HZ   = 1_000_000,
    parameter int SHORT_MS = 250,
    parameter int MID_MS   = 500,
    parameter int LONG_MS  = 1000,
    parameter int PULSE_MS = 250
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr_en,
    input  logic [7:0] reg_wr_data,
    output logic [7:0] reg_rd_data,
    input  logic       strobe_in,
    output logic       wd_rst_n
);
    import wdt_pkg::*;

    localparam int CYCLES_PER_MS = CLK_HZ / 1000;

    delay_code_t code;
    logic        ms_tick;
    logic        tick_clr;
    logic        strobe_fall;

    wdt_ctrl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_data (reg_wr_data),
        .rd_data (reg_rd_data),
        .code    (code)
    );

    wdt_strobe_sync u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_in  (strobe_in),
        .fall_pulse (strobe_fall)
    );

    wdt_tick_gen #(
        .CYCLES_PER_MS (CYCLES_PER_MS)
    ) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_clr (tick_clr),
        .ms_tick  (ms_tick)
    );

    wdt_timer_core #(
        .SHORT_MS (SHORT_MS),
        .MID_MS   (MID_MS),
        .LONG_MS  (LONG_MS),
        .PULSE_MS (PULSE_MS)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .ms_tick     (ms_tick),
        .strobe_fall (strobe_fall),
        .cfg_write   (reg_wr_en),
        .code        (code),
        .tick_clr    (tick_clr),
        .rst_out_n   (wd_rst_n)
    );
endmodule

// File: tb/test_wdt_supervisor.sv
// Bench for wdt_supervisor with short periods: 4 cycles per ms,
// periods 5/10/20 ms, pulse 3 ms.
module test_wdt_supervisor;
    localparam int CLK_PERIOD = 10;
    localparam int CPM   = 4;
    localparam int P_S   = 5;
    localparam int P_M   = 10;
    localparam int P_L   = 20;
    localparam int P_PLS = 3;
    localparam int PULSE_CYC = P_PLS * CPM;

    // Each entry: {write data, expected read, expected cycles to expiry (0 = none)}
    localparam logic [31:0] VEC [4] = '{
        {8'hFD, 8'h01, 16'(P_S * CPM + 1)},
        {8'h06, 8'h02, 16'(P_M * CPM + 1)},
        {8'h03, 8'h03, 16'(P_L * CPM + 1)},
        {8'hFC, 8'h00, 16'd0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wr_data = 8'h00;
    logic [7:0] reg_rd_data;
    logic       strobe_in = 1'b0;
    logic       wd_rst_n;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wdt_supervisor #(
        .CLK_HZ   (CPM * 1000),
        .SHORT_MS (P_S),
        .MID_MS   (P_M),
        .LONG_MS  (P_L),
        .PULSE_MS (P_PLS)
    ) i_wdt_supervisor (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .reg_rd_data (reg_rd_data),
        .strobe_in   (strobe_in),
        .wd_rst_n    (wd_rst_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Count edges until wd_rst_n is seen low; optionally move strobe.
    task automatic wait_fall(input int limit, input int hi_at, input int lo_at,
                             output int n, output bit seen);
        n = 0;
        seen = 1'b0;
        while (n < limit) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            reg_wr_en = 1'b0;
            if (n == hi_at) strobe_in = 1'b1;
            if (n == lo_at) strobe_in = 1'b0;
            if (!wd_rst_n) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    // Count edges until wd_rst_n is seen high; optionally toggle strobe.
    task automatic wait_rise(input bit wiggle, output int n);
        n = 0;
        while (n < 1000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (wiggle && n == 1) strobe_in = 1'b1;
            if (wiggle && n == 3) strobe_in = 1'b0;
            if (wd_rst_n) break;
        end
    endtask

    task automatic do_write(input logic [7:0] d);
        reg_wr_en   = 1'b1;
        reg_wr_data = d;
        @(negedge clk);
        reg_wr_en   = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int  n;
        bit  seen;

        repeat (3) @(negedge clk);
        // R2 reset state
        check(wd_rst_n == 1'b1, "R2 reset output", int'(wd_rst_n), 1);
        check(reg_rd_data == 8'h03, "R2 reset code", int'(reg_rd_data), 3);
        rst_n = 1'b1;
        wait_fall(500, -1, -1, n, seen);
        check(seen && n == P_L * CPM, "R2 first expiry after reset", n, P_L * CPM);
        wait_rise(1'b0, n);
        check(n == PULSE_CYC, "R5 pulse length", n, PULSE_CYC);

        // R1 / R6 / R7: table walk
        for (int i = 0; i < 4; i++) begin
            reg_wr_en   = 1'b1;
            reg_wr_data = VEC[i][31:24];
            wait_fall(200, -1, -1, n, seen);
            check(reg_rd_data == VEC[i][23:16], "R6 read value",
                  int'(reg_rd_data), int'(VEC[i][23:16]));
            if (VEC[i][15:0] == 16'd0) begin
                check(!seen, "R7 disabled no expiry", int'(seen), 0);
            end else begin
                check(seen && n == int'(VEC[i][15:0]), "R1 period", n, int'(VEC[i][15:0]));
                wait_rise(1'b0, n);
                check(n == PULSE_CYC, "R5 pulse length", n, PULSE_CYC);
            end
        end

        // R3: rising edge does not restart
        reg_wr_en = 1'b1; reg_wr_data = 8'h01;
        wait_fall(200, 1, -1, n, seen);
        check(seen && n == P_S * CPM + 1, "R3 rising edge ignored", n, P_S * CPM + 1);
        wait_rise(1'b0, n);

        // R3: falling edge restarts, three edges after the strobe change
        reg_wr_en = 1'b1; reg_wr_data = 8'h01;
        strobe_in = 1'b1;
        wait_fall(200, -1, 5, n, seen);
        check(seen && n == 8 + P_S * CPM, "R3 falling edge restart", n, 8 + P_S * CPM);

        // R4: strobe during pulse ignored, count restarts at pulse end
        wait_rise(1'b1, n);
        check(n == PULSE_CYC, "R4 pulse unaffected by strobe", n, PULSE_CYC);
        wait_fall(200, -1, -1, n, seen);
        check(seen && n == P_S * CPM, "R4 count from pulse end", n, P_S * CPM);
        wait_rise(1'b0, n);

        // R7: disable just before expiry suppresses it
        do_write(8'h01);
        repeat (15) @(negedge clk);
        do_write(8'h00);
        wait_fall(300, -1, -1, n, seen);
        check(!seen, "R7 pending timeout suppressed", int'(seen), 0);
        reg_wr_en = 1'b1; reg_wr_data = 8'h01;
        wait_fall(200, -1, -1, n, seen);
        check(seen && n == P_S * CPM + 1, "R7 re-enable from zero", n, P_S * CPM + 1);
        wait_rise(1'b0, n);

        // R8: code change mid-count restarts with the new period
        do_write(8'h03);
        repeat (30) @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_data = 8'h02;
        wait_fall(300, -1, -1, n, seen);
        check(seen && n == P_M * CPM + 1, "R8 new period on write", n, P_M * CPM + 1);
        wait_rise(1'b0, n);

        // R2: reset mid-run restores default
        repeat (7) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(reg_rd_data == 8'h03, "R2 reset restores code", int'(reg_rd_data), 3);
        check(wd_rst_n == 1'b1, "R2 reset output high", int'(wd_rst_n), 1);
        rst_n = 1'b1;
        wait_fall(500, -1, -1, n, seen);
        check(seen && n == P_L * CPM, "R2 expiry after mid-run reset", n, P_L * CPM);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule